// File: doc/BRIEF.md
# Receive Overhead Serial Output Port

This block takes overhead that a receive framer has already pulled out of incoming frames and plays it out on a narrow serial port made of an overhead clock, a data line, a frame pulse and an enable line. The framer hands over one overhead item per strobe, together with a marker for the first item of a frame or group and a marker that says whether the item is path overhead. Items wait in a small FIFO and are shifted out one bit per overhead-clock period.

Three modes are supported. In the two bit modes (DS3 and E3) every queued item carries a single overhead bit. In STS-1 mode every item is a byte: the 27 transport overhead bytes of a frame are queued first, then its 9 path overhead bytes, and each byte leaves most significant bit first. One frame pulse marks both the first transport byte and the first path byte, and the enable line shows which of the two it is. A mode change waits for a frame boundary, then clears the FIFO and switches.

The overhead clock is derived from the system clock and runs all the time. Every output changes only when that clock falls, so a downstream receiver samples on its rising edge.

Top module: `rxoh_serial_port`

## Requirements
- R1: While and after reset, ohSer, ohFrame, ohEnable and ohOverflow are low, and the active mode is taken from modeIn.
- R2: ohSer, ohFrame and ohEnable change only in the system clock cycle in which ohClk goes from high to low.
- R3: ohClk toggles every DIV_HALF system clocks without pause, whether or not overhead is queued.
- R4: With modeIn 0 (DS3) or 1 (E3) each queued item yields one output bit equal to bit 0 of ohData, and ohFrame is high for exactly that bit period when the item had ohStart set.
- R5: With modeIn 2 (STS-1) each queued item yields eight output bits, ohData bit 7 first and bit 0 last.
- R6: In STS-1 mode ohFrame is high only during the first bit of an item queued with ohStart set (the first transport byte and the first path byte of a frame).
- R7: In STS-1 mode ohEnable is high for all eight bits of an item queued with ohIsPath low and low for an item with ohIsPath high; in the bit modes ohEnable stays low.
- R8: The FIFO holds DEPTH items; while it is not empty, bits leave back to back with no idle period between items.
- R9: An item offered while the FIFO is full is dropped and sets ohOverflow, which stays high until reset.
- R10: When no item is being shifted and none is queued, ohSer, ohFrame and ohEnable are low.
- R11: A new modeIn value takes effect only while no item is being shifted and the FIFO is empty or its head is a frame-start transport item; the FIFO is cleared at that moment, so items already in flight keep the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| modeIn | input | 2 | Requested mode: 0 DS3, 1 E3, 2 STS-1 |
| ohValid | input | 1 | Framer offers an overhead item |
| ohData | input | 8 | Overhead byte, or overhead bit in bit 0 |
| ohStart | input | 1 | Item is the first of a frame or overhead group |
| ohIsPath | input | 1 | Item is path overhead |
| ohClk | output | 1 | Free-running overhead clock |
| ohSer | output | 1 | Serial overhead data |
| ohFrame | output | 1 | Frame pulse |
| ohEnable | output | 1 | High during transport overhead bytes |
| ohOverflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The two functions that meet in one cycle are a framer write into the FIFO and the serializer popping the head item at an overhead-clock fall; the bench provokes this by writing a whole frame at one item per system clock while draining is already under way, and judges it by requiring the captured bit stream, from the first frame pulse onward, to match the rebuilt overhead with no gap or repeat. A second collision is a mode request arriving while a bit-mode frame is still in flight; that frame must still come out one bit per item, and the following STS-1 frame must come out as bytes.

// File: rtl/rxoh_pkg.sv
package rxoh_pkg;

  typedef enum logic [1:0] {
    MODE_DS3  = 2'd0,
    MODE_E3   = 2'd1,
    MODE_STS1 = 2'd2
  } ohMode_e;

  // strobes from control to datapath, all valid for one system clock
  typedef struct packed {
    logic tick;      // overhead clock falls this cycle
    logic load;      // pop head item into the serializer
    logic shift;     // advance to next bit of current byte
    logic flush;     // clear FIFO at a mode change
    logic byteMode;  // active mode is STS-1
  } ohStrobe_t;

endpackage

// File: rtl/rxoh_ctrl.sv
module rxoh_ctrl
  import rxoh_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeIn,
  input  logic       fifoEmpty,
  input  logic       headStart,
  output ohStrobe_t  strb,
  output logic       ohClk
);

  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] divCnt;
  logic          ohClkR;
  logic [2:0]    bitsLeft;
  logic [1:0]    activeMode;
  logic          busy;
  logic          pending;
  logic          atBoundary;
  logic          fallNow;

  assign busy       = (bitsLeft != 3'd0);
  assign pending    = (modeIn != activeMode);
  assign atBoundary = !busy && (fifoEmpty || headStart);
  assign fallNow    = (divCnt == DIV_LAST) && ohClkR;

  always_comb begin
    strb.tick     = fallNow;
    strb.byteMode = (activeMode == MODE_STS1);
    strb.flush    = fallNow && pending && atBoundary;
    strb.load     = fallNow && !busy && !fifoEmpty && !strb.flush;
    strb.shift    = fallNow && busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt     <= '0;
      ohClkR     <= 1'b0;
      bitsLeft   <= 3'd0;
      activeMode <= modeIn;
    end else begin
      if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        ohClkR <= ~ohClkR;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (strb.flush) activeMode <= modeIn;
      if (strb.load)       bitsLeft <= strb.byteMode ? 3'd7 : 3'd0;
      else if (strb.shift) bitsLeft <= bitsLeft - 3'd1;
    end
  end

  assign ohClk = ohClkR;

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> !fifoEmpty); // R8
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(activeMode) |-> $past(fifoEmpty || headStart)); // R11

endmodule

// File: rtl/rxoh_datapath.sv
module rxoh_datapath
  import rxoh_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  ohStrobe_t  strb,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrStart,
  input  logic       wrPath,
  output logic       fifoEmpty,
  output logic       headStart,
  output logic       ohSer,
  output logic       ohFrame,
  output logic       ohEnable,
  output logic       ohOverflow
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    memData  [DEPTH];
  logic          memStart [DEPTH];
  logic          memPath  [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full, wrOk;
  logic [7:0]    headData;
  logic          headFirst, headPath;
  logic [7:0]    shReg;
  logic          serR, frameR, enR, ovfR;

  assign full      = (count == CW'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign wrOk      = wrValid && !full && !strb.flush;
  assign headData  = memData[rdPtr];
  assign headFirst = memStart[rdPtr];
  assign headPath  = memPath[rdPtr];
  assign headStart = !fifoEmpty && headFirst && !headPath;

  always_ff @(posedge clk) begin
    if (wrOk) begin
      memData[wrPtr]  <= wrData;
      memStart[wrPtr] <= wrStart;
      memPath[wrPtr]  <= wrPath;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovfR  <= 1'b0;
    end else begin
      if (wrValid && full && !strb.flush) ovfR <= 1'b1;
      if (strb.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (wrOk)      wrPtr <= wrPtr + 1'b1;
        if (strb.load) rdPtr <= rdPtr + 1'b1;
        count <= count + CW'(wrOk) - CW'(strb.load);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg  <= '0;
      serR   <= 1'b0;
      frameR <= 1'b0;
      enR    <= 1'b0;
    end else if (strb.load) begin
      serR   <= strb.byteMode ? headData[7] : headData[0];
      shReg  <= {headData[6:0], 1'b0};
      frameR <= headFirst;
      enR    <= strb.byteMode && !headPath;
    end else if (strb.shift) begin
      serR   <= shReg[7];
      shReg  <= {shReg[6:0], 1'b0};
      frameR <= 1'b0;
    end else if (strb.tick) begin
      serR   <= 1'b0;
      frameR <= 1'b0;
      enR    <= 1'b0;
    end
  end

  assign ohSer      = serR;
  assign ohFrame    = frameR;
  assign ohEnable   = enR;
  assign ohOverflow = ovfR;

  AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    !$stable({serR, frameR, enR}) |-> $past(strb.tick)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R8
  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (rst)
    $past(ovfR) |-> ovfR); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && !strb.load && !strb.shift) |=> (!serR && !frameR && !enR)); // R10
  AST_BIT_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (strb.load && !strb.byteMode) |=> !enR); // R7

endmodule

// File: rtl/rxoh_serial_port.sv
module rxoh_serial_port
  import rxoh_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeIn,
  input  logic       ohValid,
  input  logic [7:0] ohData,
  input  logic       ohStart,
  input  logic       ohIsPath,
  output logic       ohClk,
  output logic       ohSer,
  output logic       ohFrame,
  output logic       ohEnable,
  output logic       ohOverflow
);

  ohStrobe_t strb;
  logic      fifoEmpty;
  logic      headStart;

  rxoh_ctrl #(.DIV_HALF(DIV_HALF)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .modeIn    (modeIn),
    .fifoEmpty (fifoEmpty),
    .headStart (headStart),
    .strb      (strb),
    .ohClk     (ohClk)
  );

  rxoh_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .wrValid    (ohValid),
    .wrData     (ohData),
    .wrStart    (ohStart),
    .wrPath     (ohIsPath),
    .fifoEmpty  (fifoEmpty),
    .headStart  (headStart),
    .ohSer      (ohSer),
    .ohFrame    (ohFrame),
    .ohEnable   (ohEnable),
    .ohOverflow (ohOverflow)
  );

endmodule

// File: tb/rxoh_serial_port_bench.sv
module rxoh_serial_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;
  localparam int DEPTH      = 64;
  localparam int NVEC       = 5;
  // mode, item count, pattern seed
  localparam int VEC [NVEC][3] = '{
    '{0, 56, 3}, '{1, 12, 5}, '{2, 36, 7}, '{0, 56, 11}, '{2, 36, 13}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeIn = 2'd0;
  logic       ohValid = 1'b0;
  logic [7:0] ohData = 8'd0;
  logic       ohStart = 1'b0;
  logic       ohIsPath = 1'b0;
  logic       ohClk, ohSer, ohFrame, ohEnable, ohOverflow;

  rxoh_serial_port #(.DEPTH(DEPTH), .DIV_HALF(DIV_HALF)) u_rxoh_serial_port (
    .clk(clk), .rst(rst), .modeIn(modeIn), .ohValid(ohValid), .ohData(ohData),
    .ohStart(ohStart), .ohIsPath(ohIsPath), .ohClk(ohClk), .ohSer(ohSer),
    .ohFrame(ohFrame), .ohEnable(ohEnable), .ohOverflow(ohOverflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   nChecks = 0;
  int   nFails  = 0;
  logic obsSer [512];
  logic obsFrm [512];
  logic obsEn  [512];
  int   obsN = 0;
  logic capture = 1'b0;
  logic prevClk = 1'b0;
  logic [2:0] prevOut = 3'b0;
  int   sinceToggle = 0;
  logic seenToggle = 1'b0;
  int   clkRunBad = 0;
  int   edgeBad = 0;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      seenToggle = 1'b0;
    end else begin
      if (ohClk != prevClk) begin
        if (seenToggle && sinceToggle != DIV_HALF) clkRunBad++;
        seenToggle = 1'b1;
        sinceToggle = 1;
      end else begin
        sinceToggle++;
      end
      if ({ohSer, ohFrame, ohEnable} != prevOut && !(prevClk && !ohClk)) edgeBad++;
      if (capture && ohClk && !prevClk && obsN < 512) begin
        obsSer[obsN] = ohSer;
        obsFrm[obsN] = ohFrame;
        obsEn[obsN]  = ohEnable;
        obsN++;
      end
    end
    prevClk = ohClk;
    prevOut = {ohSer, ohFrame, ohEnable};
  end

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [7:0] patOf(input int seed, input int i);
    return 8'(seed * 53 + i * 29 + (i >> 2));
  endfunction

  function automatic logic startOf(input int mode, input int i);
    return (i == 0) || (mode == 2 && i == 27);
  endfunction

  function automatic logic pathOf(input int mode, input int i);
    return (mode == 2) && (i >= 27);
  endfunction

  task automatic pushItems(input int mode, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ohValid  = 1'b1;
      ohData   = patOf(seed, i);
      ohStart  = startOf(mode, i);
      ohIsPath = pathOf(mode, i);
    end
    @(negedge clk);
    ohValid = 1'b0;
    ohStart = 1'b0;
    ohIsPath = 1'b0;
  endtask

  // push one frame, rebuild its bit stream and compare (R4..R8, R10)
  task automatic runFrame(input int mode, input int n, input int seed, input int switchTo);
    int bitsPer;
    int nb;
    int first;
    int guard;
    bitsPer = (mode == 2) ? 8 : 1;
    nb = bitsPer * n;
    obsN = 0;
    capture = 1'b1;
    pushItems(mode, n, seed);
    if (switchTo >= 0) modeIn = 2'(switchTo);
    guard = 0;
    while (obsN < nb + 16 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    capture = 1'b0;
    first = -1;
    for (int k = 0; k < obsN; k++)
      if (first < 0 && obsFrm[k]) first = k;
    check("R4 R6 first frame pulse found", int'(first >= 0), 1);
    if (first < 0) first = 0;
    for (int j = 0; j < nb; j++) begin
      int e;
      int b;
      logic [7:0] d;
      logic eSer, eFrm, eEn;
      e = j / bitsPer;
      b = j % bitsPer;
      d = patOf(seed, e);
      eSer = (mode == 2) ? d[7-b] : d[0];
      eFrm = (b == 0) && startOf(mode, e);
      eEn  = (mode == 2) && !pathOf(mode, e);
      if (first + j < 512) begin
        if (mode == 2)
          check("R5 R6 R7 R8 sts1 bit", int'({obsSer[first+j], obsFrm[first+j], obsEn[first+j]}),
                int'({eSer, eFrm, eEn}));
        else
          check("R4 R7 R8 bit-mode bit", int'({obsSer[first+j], obsFrm[first+j], obsEn[first+j]}),
                int'({eSer, eFrm, eEn}));
      end
    end
    for (int j = nb; j < nb + 4; j++)
      if (first + j < obsN)
        check("R10 idle after drain", int'({obsSer[first+j], obsFrm[first+j], obsEn[first+j]}), 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog expired: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 reset outputs", int'({ohSer, ohFrame, ohEnable, ohOverflow}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", int'({ohSer, ohFrame, ohEnable, ohOverflow}), 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      modeIn = 2'(VEC[v][0]);
      repeat (20) @(negedge clk);
      runFrame(VEC[v][0], VEC[v][1], VEC[v][2], -1);
    end

    // R11: mode request while a DS3 frame is in flight
    modeIn = 2'd0;
    repeat (20) @(negedge clk);
    runFrame(0, 56, 21, 2);
    runFrame(2, 36, 23, -1);

    // R9: overflow in STS-1 mode
    pushItems(2, 80, 31);
    @(negedge clk);
    check("R9 overflow flag set", int'(ohOverflow), 1);
    repeat (3000) @(negedge clk);
    check("R9 overflow flag sticky", int'(ohOverflow), 1);
    check("R10 idle outputs low", int'({ohSer, ohFrame, ohEnable}), 0);

    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 overflow cleared by reset", int'(ohOverflow), 0);
    repeat (40) @(negedge clk);
    check("R10 idle after reset", int'({ohSer, ohFrame, ohEnable}), 0);

    check("R3 overhead clock toggle spacing errors", clkRunBad, 0);
    check("R2 output changes off falling edge", edgeBad, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule